// File: doc/BRIEF.md
# Set-Associative Instruction Address Translator

This block turns an instruction-fetch virtual address into a physical address through a small set-associative table. Each way keeps, for every set, a match entry (virtual tag, valid bit, a small saturating usage counter) and a translate entry (physical page number, user-execute enable, supervisor-execute enable, cache-inhibit). On a fetch the block reports a hit, a miss or an execute-permission fault in the same cycle. It also returns the physical address and the cache-inhibit flag. On a clock edge with a valid fetch that hits, it ages the usage counters of the addressed set.

Software fills and inspects the table through a register port that addresses one entry at a time by table, way and set. A second, side-effect-free lookup port serves a debugger. When translation is switched off or the unit is absent, both ports pass the address through. Refill, exception handling and statistics belong to the surrounding core.

Top module: `itlb_xlate`

## Requirements
- R1: With `xl_en` low, `fetch_pa` equals `fetch_va`, `fetch_ci` equals bit 31 of `fetch_va` (set at or above 0x8000_0000), and `fetch_hit`, `fetch_miss` and `fetch_fault` stay low.
- R2: The set is the virtual address divided by the page size, modulo the set count (bits [14:13] at defaults). The tag is the address divided by page size times set count (bits [31:15]). A way hits only when its valid bit is set and its stored tag equals this tag.
- R3: When several ways of a set hit, the highest-numbered way supplies the translation.
- R4: On a hit in supervisor mode (`fetch_sup` high) with the supervisor-execute bit clear, or in user mode with the user-execute bit clear, `fetch_fault` is raised together with `fetch_hit`.
- R5: On a clock edge where a valid fetch hits, the hitting way's usage counter is loaded with USTATES-1. Every other way of that set with a nonzero counter is decremented by one, and a zero counter stays zero.
- R6: On a hit, `fetch_pa` is the entry's physical page number followed by the page-offset bits of `fetch_va`, and `fetch_ci` is the entry's cache-inhibit bit.
- R7: On a miss, `fetch_miss` is high, `fetch_pa` is zero, `fetch_ci` is low, and no table content changes.
- R8: The debug port returns the translated address on a permitted hit, zero on a miss or permission failure, and `dbg_va` when translation is off. It never changes the usage counters.
- R9: A register-port write lands on the next clock edge. `cfg_rdata` shows the entry addressed by `cfg_xlat`, `cfg_way` and `cfg_set`. Match word: tag in bits [31:15], usage counter in bits [2:1], valid in bit 0. Translate word: page number in bits [31:13], supervisor-execute bit 2, user-execute bit 1, cache-inhibit bit 0.
- R10: When a match-entry write and a counter update hit the same entry on one edge, the written counter value wins.
- R11: A synchronous active-low reset clears every valid bit and usage counter, so the first fetch after reset misses.
- R12: With `mmu_present` low, the block behaves as with translation off, whatever `xl_en` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xl_en | input | 1 | Translation enable |
| mmu_present | input | 1 | Unit implemented; low forces pass-through |
| fetch_vld | input | 1 | Fetch request valid this cycle |
| fetch_sup | input | 1 | Fetch runs in supervisor mode |
| fetch_va | input | 32 | Fetch virtual address |
| fetch_hit | output | 1 | Tag hit (includes faulting hits) |
| fetch_miss | output | 1 | No valid way matched |
| fetch_fault | output | 1 | Hit without execute permission |
| fetch_pa | output | 32 | Physical address |
| fetch_ci | output | 1 | Cache-inhibit for this fetch |
| dbg_va | input | 32 | Debug lookup address |
| dbg_pa | output | 32 | Debug lookup result |
| cfg_we | input | 1 | Register-port write strobe |
| cfg_xlat | input | 1 | 0 selects match table, 1 translate table |
| cfg_way | input | 1 | Way select |
| cfg_set | input | 2 | Set select |
| cfg_wdata | input | 32 | Entry write data |
| cfg_rdata | output | 32 | Entry read data |

## Verification
The assertions check on every cycle that miss results are zero and that a fault is always a hit. They also check that the hitting way is the highest matching one and that the pass-through path copies the address. Each hit must leave the winning counter at its maximum, a cycle with no update and no match write must keep every counter, and a match write must override any concurrent aging. The translated address values, field placement in the register words, the decrement-and-saturate pattern across ways, the debug port leaving counters alone, and reset clearing valid entries depend on programmed contents, so only the bench's scenarios show them.

// File: rtl/itlb_pkg.sv
// Shared constants for the instruction translator: address width and
// the bit positions of the flag fields inside register-port words.
// Assumes a 32-bit virtual and physical address space.
package itlb_pkg;
    localparam int VA_W      = 32;
    // match word flag positions
    localparam int VALID_BIT = 0;
    localparam int LRU_LSB   = 1;
    // translate word flag positions
    localparam int CI_BIT    = 0;
    localparam int UXE_BIT   = 1;
    localparam int SXE_BIT   = 2;

    typedef enum logic {
        TBL_MATCH = 1'b0,
        TBL_XLAT  = 1'b1
    } tbl_sel_e;
endpackage

// File: rtl/itlb_store.sv
// Entry storage for all ways and sets, plus usage-counter aging.
// Owns the register-port write and read paths. A match-entry write
// overrides a same-edge counter update for the entry it addresses.
// Assumes PAGE_LOG2 >= 3 so the flag bits sit below the page number.
module itlb_store
    import itlb_pkg::*;
#(
    parameter int NWAYS      = 2,
    parameter int NSETS_LOG2 = 2,
    parameter int PAGE_LOG2  = 13,
    parameter int USTATES    = 4,
    localparam int NSETS   = 1 << NSETS_LOG2,
    localparam int TAG_LSB = PAGE_LOG2 + NSETS_LOG2,
    localparam int TAG_W   = VA_W - TAG_LSB,
    localparam int PPN_W   = VA_W - PAGE_LOG2,
    localparam int WAY_W   = (NWAYS > 1) ? $clog2(NWAYS) : 1,
    localparam int LRU_W   = (USTATES > 2) ? $clog2(USTATES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic                  cfg_xlat,
    input  logic [WAY_W-1:0]      cfg_way,
    input  logic [NSETS_LOG2-1:0] cfg_set,
    input  logic [VA_W-1:0]       cfg_wdata,
    output logic [VA_W-1:0]       cfg_rdata,
    input  logic                  upd_en,
    input  logic [WAY_W-1:0]      upd_way,
    input  logic [NSETS_LOG2-1:0] upd_set,
    output logic [TAG_W-1:0]      tag_q   [NWAYS][NSETS],
    output logic                  valid_q [NWAYS][NSETS],
    output logic [PPN_W-1:0]      ppn_q   [NWAYS][NSETS],
    output logic                  ci_q    [NWAYS][NSETS],
    output logic                  uxe_q   [NWAYS][NSETS],
    output logic                  sxe_q   [NWAYS][NSETS]
);
    localparam logic [LRU_W-1:0] LRU_MAX = LRU_W'(USTATES - 1);

    logic [LRU_W-1:0] lru_q [NWAYS][NSETS];
    logic wr_match, wr_xlat, way_ok;
    logic [NWAYS*NSETS*LRU_W-1:0] lru_flat;
    logic unused_wdata;

    assign way_ok   = (int'(cfg_way) < NWAYS);
    assign wr_match = cfg_we && (cfg_xlat == TBL_MATCH) && way_ok;
    assign wr_xlat  = cfg_we && (cfg_xlat == TBL_XLAT) && way_ok;
    assign unused_wdata = ^cfg_wdata;

    // Valid bits and usage counters: reset, register writes, aging on hits.
    always_ff @(posedge clk) begin
        for (int w = 0; w < NWAYS; w++) begin
            for (int s = 0; s < NSETS; s++) begin
                if (!rst_n) begin
                    valid_q[w][s] <= 1'b0;
                    lru_q[w][s]   <= '0;
                end else begin
                    if (wr_match && int'(cfg_way) == w && int'(cfg_set) == s) begin
                        valid_q[w][s] <= cfg_wdata[VALID_BIT];
                        lru_q[w][s]   <= cfg_wdata[LRU_LSB +: LRU_W];
                    end else if (upd_en && int'(upd_set) == s) begin
                        if (int'(upd_way) == w)
                            lru_q[w][s] <= LRU_MAX;
                        else if (lru_q[w][s] != '0)
                            lru_q[w][s] <= lru_q[w][s] - 1'b1;
                    end
                end
            end
        end
    end

    // Tags, page numbers and permission flags: written only by software.
    always_ff @(posedge clk) begin
        for (int w = 0; w < NWAYS; w++) begin
            for (int s = 0; s < NSETS; s++) begin
                if (wr_match && int'(cfg_way) == w && int'(cfg_set) == s)
                    tag_q[w][s] <= cfg_wdata[VA_W-1:TAG_LSB];
                if (wr_xlat && int'(cfg_way) == w && int'(cfg_set) == s) begin
                    ppn_q[w][s] <= cfg_wdata[VA_W-1:PAGE_LOG2];
                    ci_q[w][s]  <= cfg_wdata[CI_BIT];
                    uxe_q[w][s] <= cfg_wdata[UXE_BIT];
                    sxe_q[w][s] <= cfg_wdata[SXE_BIT];
                end
            end
        end
    end

    // Read path: rebuild the addressed word in register-port layout.
    always_comb begin
        cfg_rdata = '0;
        if (way_ok) begin
            if (cfg_xlat == TBL_XLAT) begin
                cfg_rdata[VA_W-1:PAGE_LOG2] = ppn_q[cfg_way][cfg_set];
                cfg_rdata[CI_BIT]           = ci_q[cfg_way][cfg_set];
                cfg_rdata[UXE_BIT]          = uxe_q[cfg_way][cfg_set];
                cfg_rdata[SXE_BIT]          = sxe_q[cfg_way][cfg_set];
            end else begin
                cfg_rdata[VA_W-1:TAG_LSB]       = tag_q[cfg_way][cfg_set];
                cfg_rdata[LRU_LSB +: LRU_W]     = lru_q[cfg_way][cfg_set];
                cfg_rdata[VALID_BIT]            = valid_q[cfg_way][cfg_set];
            end
        end
    end

    // Flatten counters for whole-table stability checks.
    for (genvar gw = 0; gw < NWAYS; gw++) begin : g_flat_w
        for (genvar gs = 0; gs < NSETS; gs++) begin : g_flat_s
            assign lru_flat[(gw*NSETS+gs)*LRU_W +: LRU_W] = lru_q[gw][gs];
        end
    end

    // Checker state: remember last update and last match write.
    logic                  upd_chk, wr_chk;
    logic [WAY_W-1:0]      upd_chk_way, wr_chk_way;
    logic [NSETS_LOG2-1:0] upd_chk_set, wr_chk_set;
    logic [LRU_W-1:0]      wr_chk_val;

    // Capture what the next edge's counters must show.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_chk <= 1'b0;
            wr_chk  <= 1'b0;
        end else begin
            upd_chk <= upd_en && !(wr_match && cfg_way == upd_way && cfg_set == upd_set);
            wr_chk  <= wr_match;
        end
        upd_chk_way <= upd_way;
        upd_chk_set <= upd_set;
        wr_chk_way  <= cfg_way;
        wr_chk_set  <= cfg_set;
        wr_chk_val  <= cfg_wdata[LRU_LSB +: LRU_W];
    end

    // R5: the hitting way's counter reaches its maximum.
    a_r5_hit_loads_max: assert property (@(posedge clk) disable iff (!rst_n)
        upd_chk |-> lru_q[upd_chk_way][upd_chk_set] == LRU_MAX);

    // R7: with no hit update and no match write, no counter moves.
    a_r7_counters_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !wr_match) |=> $stable(lru_flat));

    // R10: a match write sets the counter even if a hit ages that entry.
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_chk |-> lru_q[wr_chk_way][wr_chk_set] == wr_chk_val);
endmodule

// File: rtl/itlb_lookup.sv
// Combinational tag compare for one lookup port: picks the set from the
// address, finds the highest valid matching way, checks execute
// permission for the given mode and forms the physical address.
// Clock and reset serve only the embedded assertions.
module itlb_lookup
    import itlb_pkg::*;
#(
    parameter int NWAYS      = 2,
    parameter int NSETS_LOG2 = 2,
    parameter int PAGE_LOG2  = 13,
    localparam int NSETS   = 1 << NSETS_LOG2,
    localparam int TAG_LSB = PAGE_LOG2 + NSETS_LOG2,
    localparam int TAG_W   = VA_W - TAG_LSB,
    localparam int PPN_W   = VA_W - PAGE_LOG2,
    localparam int WAY_W   = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [VA_W-1:0]       va,
    input  logic                  sup,
    input  logic [TAG_W-1:0]      tag_q   [NWAYS][NSETS],
    input  logic                  valid_q [NWAYS][NSETS],
    input  logic [PPN_W-1:0]      ppn_q   [NWAYS][NSETS],
    input  logic                  ci_q    [NWAYS][NSETS],
    input  logic                  uxe_q   [NWAYS][NSETS],
    input  logic                  sxe_q   [NWAYS][NSETS],
    output logic                  match,
    output logic [WAY_W-1:0]      way,
    output logic [NSETS_LOG2-1:0] set_idx,
    output logic                  perm,
    output logic [VA_W-1:0]       pa,
    output logic                  ci
);
    logic [TAG_W-1:0] va_tag;
    logic [NWAYS-1:0] way_hit;

    assign set_idx = va[TAG_LSB-1:PAGE_LOG2];
    assign va_tag  = va[VA_W-1:TAG_LSB];

    // One comparator per way on the selected set.
    for (genvar gw = 0; gw < NWAYS; gw++) begin : g_cmp
        assign way_hit[gw] = valid_q[gw][set_idx] && (tag_q[gw][set_idx] == va_tag);
    end

    // Highest-numbered matching way wins.
    always_comb begin
        way = '0;
        for (int w = 0; w < NWAYS; w++)
            if (way_hit[w]) way = WAY_W'(w);
    end

    // Permission, address and cache-inhibit from the chosen way.
    always_comb begin
        match = |way_hit;
        perm  = sup ? sxe_q[way][set_idx] : uxe_q[way][set_idx];
        pa    = {ppn_q[way][set_idx], va[PAGE_LOG2-1:0]};
        ci    = ci_q[way][set_idx];
    end

    // R3: no higher way than the chosen one also matches.
    a_r3_highest_way: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (way_hit >> way) == NWAYS'(1));

    // R2: a reported match always rests on a valid entry.
    a_r2_match_valid: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> valid_q[way][set_idx]);
endmodule

// File: rtl/itlb_xlate.sv
// Top of the instruction translator: one storage block, a fetch lookup
// with counter aging and a side-effect-free debug lookup. Handles the
// translation-off pass-through and the hit/miss/fault outputs.
// Assumes NWAYS in 1..4, NSETS_LOG2 in 1..8, USTATES in 2..4.
module itlb_xlate
    import itlb_pkg::*;
#(
    parameter int NWAYS      = 2,
    parameter int NSETS_LOG2 = 2,
    parameter int PAGE_LOG2  = 13,
    parameter int USTATES    = 4,
    localparam int NSETS   = 1 << NSETS_LOG2,
    localparam int TAG_W   = VA_W - PAGE_LOG2 - NSETS_LOG2,
    localparam int PPN_W   = VA_W - PAGE_LOG2,
    localparam int WAY_W   = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  xl_en,
    input  logic                  mmu_present,
    input  logic                  fetch_vld,
    input  logic                  fetch_sup,
    input  logic [VA_W-1:0]       fetch_va,
    output logic                  fetch_hit,
    output logic                  fetch_miss,
    output logic                  fetch_fault,
    output logic [VA_W-1:0]       fetch_pa,
    output logic                  fetch_ci,
    input  logic [VA_W-1:0]       dbg_va,
    output logic [VA_W-1:0]       dbg_pa,
    input  logic                  cfg_we,
    input  logic                  cfg_xlat,
    input  logic [WAY_W-1:0]      cfg_way,
    input  logic [NSETS_LOG2-1:0] cfg_set,
    input  logic [VA_W-1:0]       cfg_wdata,
    output logic [VA_W-1:0]       cfg_rdata
);
    logic [TAG_W-1:0] tag_q   [NWAYS][NSETS];
    logic             valid_q [NWAYS][NSETS];
    logic [PPN_W-1:0] ppn_q   [NWAYS][NSETS];
    logic             ci_q    [NWAYS][NSETS];
    logic             uxe_q   [NWAYS][NSETS];
    logic             sxe_q   [NWAYS][NSETS];

    logic                  xl_on;
    logic                  f_match, f_perm, f_ci, d_match, d_perm, d_ci;
    logic [WAY_W-1:0]      f_way, d_way;
    logic [NSETS_LOG2-1:0] f_set, d_set;
    logic [VA_W-1:0]       f_pa, d_pa;
    logic                  upd_en;
    logic                  unused_dbg;

    assign xl_on      = xl_en && mmu_present;
    assign upd_en     = fetch_vld && xl_on && f_match;
    assign unused_dbg = ^{d_way, d_set, d_ci};

    itlb_store #(
        .NWAYS(NWAYS), .NSETS_LOG2(NSETS_LOG2),
        .PAGE_LOG2(PAGE_LOG2), .USTATES(USTATES)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_xlat(cfg_xlat), .cfg_way(cfg_way),
        .cfg_set(cfg_set), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .upd_en(upd_en), .upd_way(f_way), .upd_set(f_set),
        .tag_q(tag_q), .valid_q(valid_q), .ppn_q(ppn_q),
        .ci_q(ci_q), .uxe_q(uxe_q), .sxe_q(sxe_q)
    );

    itlb_lookup #(
        .NWAYS(NWAYS), .NSETS_LOG2(NSETS_LOG2), .PAGE_LOG2(PAGE_LOG2)
    ) u_fetch_lu (
        .clk(clk), .rst_n(rst_n), .va(fetch_va), .sup(fetch_sup),
        .tag_q(tag_q), .valid_q(valid_q), .ppn_q(ppn_q),
        .ci_q(ci_q), .uxe_q(uxe_q), .sxe_q(sxe_q),
        .match(f_match), .way(f_way), .set_idx(f_set),
        .perm(f_perm), .pa(f_pa), .ci(f_ci)
    );

    itlb_lookup #(
        .NWAYS(NWAYS), .NSETS_LOG2(NSETS_LOG2), .PAGE_LOG2(PAGE_LOG2)
    ) u_dbg_lu (
        .clk(clk), .rst_n(rst_n), .va(dbg_va), .sup(fetch_sup),
        .tag_q(tag_q), .valid_q(valid_q), .ppn_q(ppn_q),
        .ci_q(ci_q), .uxe_q(uxe_q), .sxe_q(sxe_q),
        .match(d_match), .way(d_way), .set_idx(d_set),
        .perm(d_perm), .pa(d_pa), .ci(d_ci)
    );

    // Fetch result: pass-through when off, translation on hit, zero on miss.
    always_comb begin
        fetch_hit   = fetch_vld && xl_on && f_match;
        fetch_miss  = fetch_vld && xl_on && !f_match;
        fetch_fault = fetch_vld && xl_on && f_match && !f_perm;
        if (!xl_on) begin
            fetch_pa = fetch_va;
            fetch_ci = fetch_va[VA_W-1];
        end else if (f_match) begin
            fetch_pa = f_pa;
            fetch_ci = f_ci;
        end else begin
            fetch_pa = '0;
            fetch_ci = 1'b0;
        end
    end

    // Debug result: same compare, zero unless a permitted hit.
    always_comb begin
        if (!xl_on)                dbg_pa = dbg_va;
        else if (d_match && d_perm) dbg_pa = d_pa;
        else                       dbg_pa = '0;
    end

    // R1: translation off copies the address and raises no event.
    a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_on |-> (fetch_pa == fetch_va && !fetch_hit && !fetch_miss && !fetch_fault));

    // R7: a miss returns a zero address and no cache-inhibit.
    a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_miss |-> (fetch_pa == '0 && !fetch_ci && !fetch_hit));

    // R4: a fault is always a hit, never a miss.
    a_r4_fault_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_fault |-> (fetch_hit && !fetch_miss));

    // R8: the debug port passes the address through when off.
    a_r8_dbg_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_on |-> dbg_pa == dbg_va);
endmodule

// File: tb/itlb_xlate_test.sv
module itlb_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xl_en = 1'b0, mmu_present = 1'b1;
    logic        fetch_vld = 1'b0, fetch_sup = 1'b1;
    logic [31:0] fetch_va = '0, dbg_va = '0, cfg_wdata = '0;
    logic        fetch_hit, fetch_miss, fetch_fault, fetch_ci;
    logic [31:0] fetch_pa, dbg_pa, cfg_rdata;
    logic        cfg_we = 1'b0, cfg_xlat = 1'b0;
    logic [0:0]  cfg_way = '0;
    logic [1:0]  cfg_set = '0;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    itlb_xlate uut (
        .clk(clk), .rst_n(rst_n), .xl_en(xl_en), .mmu_present(mmu_present),
        .fetch_vld(fetch_vld), .fetch_sup(fetch_sup), .fetch_va(fetch_va),
        .fetch_hit(fetch_hit), .fetch_miss(fetch_miss), .fetch_fault(fetch_fault),
        .fetch_pa(fetch_pa), .fetch_ci(fetch_ci),
        .dbg_va(dbg_va), .dbg_pa(dbg_pa),
        .cfg_we(cfg_we), .cfg_xlat(cfg_xlat), .cfg_way(cfg_way),
        .cfg_set(cfg_set), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    typedef struct packed {
        logic        sup;
        logic [31:0] va;
        logic        hit, miss, fault, ci;
        logic [31:0] pa;
        logic [31:0] dpa;
    } vec_t;

    // sup, va, hit, miss, fault, ci, pa, debug pa
    localparam vec_t VEC [8] = '{
        '{1'b1, 32'h0000_2ABC, 1'b1, 1'b0, 1'b0, 1'b0, 32'h4000_0ABC, 32'h4000_0ABC},
        '{1'b0, 32'h0000_3FFC, 1'b1, 1'b0, 1'b0, 1'b0, 32'h4000_1FFC, 32'h4000_1FFC},
        '{1'b1, 32'h1234_5678, 1'b1, 1'b0, 1'b0, 1'b1, 32'h8765_B678, 32'h8765_B678},
        '{1'b0, 32'h1234_5678, 1'b1, 1'b0, 1'b1, 1'b1, 32'h8765_B678, 32'h0000_0000},
        '{1'b1, 32'h0000_6010, 1'b1, 1'b0, 1'b0, 1'b0, 32'h2222_0010, 32'h2222_0010},
        '{1'b1, 32'h0000_8004, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000},
        '{1'b1, 32'h0000_0004, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000},
        '{1'b0, 32'h1234_2000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic tbl, input logic way, input logic [1:0] set, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_xlat = tbl; cfg_way = way; cfg_set = set; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic tbl, input logic way, input logic [1:0] set, output logic [31:0] d);
        @(negedge clk);
        cfg_xlat = tbl; cfg_way = way; cfg_set = set;
        #1 d = cfg_rdata;
    endtask

    task automatic fetch(input logic sup, input logic [31:0] va);
        @(negedge clk);
        fetch_vld = 1'b1; fetch_sup = sup; fetch_va = va;
        @(negedge clk);
        fetch_vld = 1'b0;
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: counters and valid bits clear after reset
        rd(1'b0, 1'b1, 2'd3, r);
        check("R11 reset flags", {61'b0, r[2:0]}, 64'd0);

        // R9: program table through the register port
        wr(1'b0, 1'b0, 2'd1, 32'h0000_0001);
        wr(1'b1, 1'b0, 2'd1, 32'h4000_0006);
        wr(1'b0, 1'b1, 2'd2, 32'h1234_0001);
        wr(1'b1, 1'b1, 2'd2, 32'h8765_A005);
        wr(1'b0, 1'b0, 2'd3, 32'h0000_0001);
        wr(1'b1, 1'b0, 2'd3, 32'h1111_0006);
        wr(1'b0, 1'b1, 2'd3, 32'h0000_0001);
        wr(1'b1, 1'b1, 2'd3, 32'h2222_0006);
        wr(1'b0, 1'b0, 2'd0, 32'h0000_8000);
        wr(1'b1, 1'b0, 2'd0, 32'h3333_0006);
        rd(1'b1, 1'b1, 2'd2, r);
        check("R9 translate readback", {32'b0, r}, 64'h8765_A005);

        xl_en = 1'b1;
        // R2 R3 R4 R6 R7: vector walk
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            fetch_vld = 1'b1; fetch_sup = VEC[i].sup;
            fetch_va = VEC[i].va; dbg_va = VEC[i].va;
            #1;
            check($sformatf("R2/R3/R4/R6/R7 vector %0d", i),
                  {28'b0, fetch_hit, fetch_miss, fetch_fault, fetch_ci, fetch_pa},
                  {28'b0, VEC[i].hit, VEC[i].miss, VEC[i].fault, VEC[i].ci, VEC[i].pa});
            check($sformatf("R8 debug vector %0d", i), {32'b0, dbg_pa}, {32'b0, VEC[i].dpa});
        end
        @(negedge clk) fetch_vld = 1'b0;

        // R5: hit loads max, other ways decrement and saturate
        wr(1'b0, 1'b0, 2'd3, 32'h0000_0003);
        wr(1'b0, 1'b1, 2'd3, 32'h0000_0001);
        fetch(1'b1, 32'h0000_6000);
        rd(1'b0, 1'b1, 2'd3, r);
        check("R5 hit way at max", {32'b0, r}, 64'h7);
        rd(1'b0, 1'b0, 2'd3, r);
        check("R5 other way decremented", {32'b0, r}, 64'h1);
        fetch(1'b1, 32'h0000_6000);
        rd(1'b0, 1'b0, 2'd3, r);
        check("R5 zero counter saturates", {32'b0, r}, 64'h1);

        // R8: debug lookups leave counters alone
        wr(1'b0, 1'b0, 2'd3, 32'h0000_0005);
        @(negedge clk) dbg_va = 32'h0000_6000;
        repeat (4) @(negedge clk);
        check("R8 debug result", {32'b0, dbg_pa}, 64'h2222_0000);
        rd(1'b0, 1'b0, 2'd3, r);
        check("R8 debug no aging", {32'b0, r}, 64'h5);

        // R10: write and hit on same entry, write wins
        @(negedge clk);
        cfg_we = 1'b1; cfg_xlat = 1'b0; cfg_way = 1'b1; cfg_set = 2'd3; cfg_wdata = 32'h0000_0003;
        fetch_vld = 1'b1; fetch_sup = 1'b1; fetch_va = 32'h0000_6000;
        @(negedge clk);
        cfg_we = 1'b0; fetch_vld = 1'b0;
        rd(1'b0, 1'b1, 2'd3, r);
        check("R10 write over aging", {32'b0, r}, 64'h3);

        // R7: miss leaves entry untouched
        wr(1'b0, 1'b0, 2'd0, 32'h0000_8004);
        @(negedge clk);
        fetch_vld = 1'b1; fetch_va = 32'h0000_8000;
        #1 check("R7 miss result", {30'b0, fetch_miss, fetch_ci, fetch_pa}, {30'b0, 1'b1, 1'b0, 32'h0});
        @(negedge clk) fetch_vld = 1'b0;
        rd(1'b0, 1'b0, 2'd0, r);
        check("R7 entry unchanged", {32'b0, r}, 64'h0000_8004);

        // R1: translation off, pass-through and cache-inhibit from bit 31
        xl_en = 1'b0;
        @(negedge clk);
        fetch_vld = 1'b1; fetch_va = 32'h8000_0000; dbg_va = 32'h0000_2ABC;
        #1 check("R1 high address", {29'b0, fetch_hit, fetch_miss, fetch_fault, fetch_ci, fetch_pa},
                 {29'b0, 3'b000, 1'b1, 32'h8000_0000});
        check("R8 debug off", {32'b0, dbg_pa}, 64'h0000_2ABC);
        @(negedge clk) fetch_va = 32'h7FFF_FFFC;
        #1 check("R1 low address", {31'b0, fetch_ci, fetch_pa}, {31'b0, 1'b0, 32'h7FFF_FFFC});

        // R12: unit absent acts as off
        xl_en = 1'b1; mmu_present = 1'b0;
        @(negedge clk) fetch_va = 32'h1234_5678;
        #1 check("R12 absent passthrough", {30'b0, fetch_hit, fetch_ci, fetch_pa},
                 {30'b0, 1'b0, 1'b0, 32'h1234_5678});
        @(negedge clk) fetch_vld = 1'b0; mmu_present = 1'b1;

        // R11: reset again, former hit now misses
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fetch_vld = 1'b1; fetch_va = 32'h0000_6000;
        #1 check("R11 miss after reset", {62'b0, fetch_hit, fetch_miss}, 64'h1);
        @(negedge clk) fetch_vld = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule